// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches the processor's instruction fetch and its memory and port accesses against four programmable address slots. A control word sets up each slot: two enable bits (a local one and a global one), a type that selects instruction execution, data write, data read/write or port I/O, and a length code that gives the watched byte range. In every cycle the unit reports which slots match, whether a debug trap has to be taken, and which instruction pointer the trap resumes at.

Matching is purely combinational. A slot that matches sets its hit bit even when it is disabled, which lets a handler see every slot that matched. Only an enabled slot can raise the trap request. The merged status word has the hit mask in its low four bits and the caller's old status in the bits above. It is captured on the clock edge that ends a cycle that raised a trap or carried a force request. Exception delivery is handled by the surrounding core.

Top module: `dbg_bp_match`

## Requirements
- R1: Slot i is active when control bit 2*i (local) or bit 2*i+1 (global) is set. Either bit alone is enough.
- R2: The 2-bit length code of slot i is at control bits [18+4*i +: 2]. The codes 0, 1, 2 and 3 select 1, 2, 8 and 4 bytes.
- R3: The 2-bit type of slot i is at control bits [16+4*i +: 2], and type 00 means execute. An execute slot matches when fetch_valid_i is high and its address equals fetch_addr_i exactly. It sets its hit bit whether or not it is enabled.
- R4: Type 01 (write watch) matches only memory writes (acc_kind_i = 01). Type 11 (read/write watch) matches memory reads (00) and writes (01). A match needs acc_valid_i and an inclusive overlap of [acc_addr_i, acc_addr_i+acc_size_i-1] with [slot, slot+len-1]. A size of 0 and kind 11 never match.
- R5: Type 10 (port I/O) matches a port access (acc_kind_i = 10) under the same inclusive overlap rule, and only when the slot is enabled.
- R6: trap_o is high exactly when at least one enabled slot has its hit bit set.
- R7: When trap_o or force_i is high at a rising clock edge, status_o takes {status_i[31:4], hit_o} at that edge. Otherwise status_o holds its value.
- R8: resume_ip_o equals next_ip_i when any port I/O slot hits. Otherwise it equals fetch_addr_i.
- R9: While rst_ni is low, status_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_addr_i | input | 128 | Four slot addresses, slot i at [32*i +: 32] |
| ctrl_i | input | 32 | Enables, types and lengths for all slots |
| status_i | input | 32 | Old status word; its upper bits are kept |
| force_i | input | 1 | Capture the status even when no trap is raised |
| fetch_valid_i | input | 1 | Instruction fetch address is valid |
| fetch_addr_i | input | 32 | Current instruction pointer |
| next_ip_i | input | 32 | Address of the next instruction |
| acc_valid_i | input | 1 | Access descriptor is valid |
| acc_addr_i | input | 32 | Access byte address or port number |
| acc_size_i | input | 4 | Access size in bytes |
| acc_kind_i | input | 2 | 00 memory read, 01 memory write, 10 port I/O, 11 none |
| hit_o | output | 4 | Per-slot match mask |
| trap_o | output | 1 | Debug trap request |
| resume_ip_o | output | 32 | Instruction pointer the trap resumes at |
| status_o | output | 32 | Merged status word (registered) |

## Verification
hit_o, trap_o and resume_ip_o are combinational, so their values are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs 1 ns later. status_o goes through one register and is due after the next rising edge. The bench samples it 1 ns after that edge, against an expected value it tracked itself, including the cases where the status must hold.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
  typedef enum logic [1:0] {
    BP_EXEC = 2'b00,
    BP_DWR  = 2'b01,
    BP_IO   = 2'b10,
    BP_DRW  = 2'b11
  } bp_type_e;

  typedef enum logic [1:0] {
    ACC_RD   = 2'b00,
    ACC_WR   = 2'b01,
    ACC_IO   = 2'b10,
    ACC_NONE = 2'b11
  } acc_kind_e;

  localparam int TYPE_BASE = 16;
  localparam int LEN_BASE  = 18;
  localparam int GRP_W     = 4;

  // code 2 is the 8-byte length; other codes are code+1 bytes
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    return (code == 2'd2) ? 4'd8 : ({2'b00, code} + 4'd1);
  endfunction
endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
  import dbg_bp_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    en_i,
  input  logic [1:0]    type_i,
  input  logic [1:0]    len_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [SW-1:0] acc_size_i,
  input  logic [1:0]    acc_kind_i,
  output logic          hit_o,
  output logic          en_o,
  output logic          io_hit_o
);
  bp_type_e  ty;
  acc_kind_e kind;
  logic [AW:0] slot_lo, slot_hi, acc_lo, acc_hi;
  logic overlap;

  assign ty   = bp_type_e'(type_i);
  assign kind = acc_kind_e'(acc_kind_i);
  assign en_o = |en_i;

  // one extra bit keeps ranges at the top of the space from wrapping
  assign slot_lo = {1'b0, base_i};
  assign slot_hi = slot_lo + (AW+1)'(len_bytes(len_i)) - (AW+1)'(1);
  assign acc_lo  = {1'b0, acc_addr_i};
  assign acc_hi  = acc_lo + (AW+1)'(acc_size_i) - (AW+1)'(1);
  assign overlap = acc_valid_i && (acc_size_i != '0)
                   && (acc_lo <= slot_hi) && (slot_lo <= acc_hi);

  always_comb begin
    hit_o    = 1'b0;
    io_hit_o = 1'b0;
    unique case (ty)
      BP_EXEC: hit_o = fetch_valid_i && (fetch_addr_i == base_i);
      BP_DWR:  hit_o = overlap && (kind == ACC_WR);
      BP_DRW:  hit_o = overlap && ((kind == ACC_WR) || (kind == ACC_RD));
      BP_IO: begin
        io_hit_o = overlap && (kind == ACC_IO) && en_o;
        hit_o    = io_hit_o;
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status #(
  parameter int STAT_W = 32,
  parameter int NSLOT  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic [STAT_W-1:NSLOT]   keep_i,
  input  logic [NSLOT-1:0]        hit_i,
  output logic [STAT_W-1:0]       status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_o <= '0;
    else if (upd_i) status_o <= {keep_i, hit_i};
  end
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_bp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NSLOT  = 4,
  parameter int SIZE_W = 4,
  parameter int STAT_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSLOT*AW-1:0]   slot_addr_i,
  input  logic [TYPE_BASE+GRP_W*NSLOT-1:0] ctrl_i,
  input  logic [STAT_W-1:0]     status_i,
  input  logic                  force_i,
  input  logic                  fetch_valid_i,
  input  logic [AW-1:0]         fetch_addr_i,
  input  logic [AW-1:0]         next_ip_i,
  input  logic                  acc_valid_i,
  input  logic [AW-1:0]         acc_addr_i,
  input  logic [SIZE_W-1:0]     acc_size_i,
  input  logic [1:0]            acc_kind_i,
  output logic [NSLOT-1:0]      hit_o,
  output logic                  trap_o,
  output logic [AW-1:0]         resume_ip_o,
  output logic [STAT_W-1:0]     status_o
);
  localparam int EN_W = 2 * NSLOT;

  logic [NSLOT-1:0] en, io_hit;
  logic unused_bits;

  assign unused_bits = ^{ctrl_i[TYPE_BASE-1:EN_W], status_i[NSLOT-1:0]};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    dbg_bp_slot #(.AW(AW), .SW(SIZE_W)) u_slot (
      .base_i       (slot_addr_i[AW*i +: AW]),
      .en_i         (ctrl_i[2*i +: 2]),
      .type_i       (ctrl_i[TYPE_BASE + GRP_W*i +: 2]),
      .len_i        (ctrl_i[LEN_BASE + GRP_W*i +: 2]),
      .fetch_valid_i(fetch_valid_i),
      .fetch_addr_i (fetch_addr_i),
      .acc_valid_i  (acc_valid_i),
      .acc_addr_i   (acc_addr_i),
      .acc_size_i   (acc_size_i),
      .acc_kind_i   (acc_kind_i),
      .hit_o        (hit_o[i]),
      .en_o         (en[i]),
      .io_hit_o     (io_hit[i])
    );
  end

  assign trap_o      = |(hit_o & en);
  assign resume_ip_o = (|io_hit) ? next_ip_i : fetch_addr_i;

  dbg_bp_status #(.STAT_W(STAT_W), .NSLOT(NSLOT)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (trap_o || force_i),
    .keep_i  (status_i[STAT_W-1:NSLOT]),
    .hit_i   (hit_o),
    .status_o(status_o)
  );
endmodule

// File: rtl/dbg_bp_match_chk.sv
module dbg_bp_match_chk #(
  parameter int AW     = 32,
  parameter int NSLOT  = 4,
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] status_i,
  input logic              force_i,
  input logic              fetch_valid_i,
  input logic [AW-1:0]     fetch_addr_i,
  input logic [AW-1:0]     next_ip_i,
  input logic              acc_valid_i,
  input logic [1:0]        acc_kind_i,
  input logic [NSLOT-1:0]  hit_o,
  input logic              trap_o,
  input logic [AW-1:0]     resume_ip_o,
  input logic [STAT_W-1:0] status_o
);
  AST_TRAP_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (hit_o != '0)); // R6
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_valid_i && !acc_valid_i) |-> (hit_o == '0 && !trap_o)); // R3
  AST_STATUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o || force_i) |=> (status_o == {$past(status_i[STAT_W-1:NSLOT]), $past(hit_o)})); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_o && !force_i) |=> $stable(status_o)); // R7
  AST_IO_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_valid_i && acc_valid_i && acc_kind_i == 2'b10 && hit_o != '0)
      |-> (resume_ip_o == next_ip_i)); // R8
  AST_NO_IO_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_kind_i != 2'b10) |-> (resume_ip_o == fetch_addr_i)); // R8
endmodule

bind dbg_bp_match dbg_bp_match_chk #(.AW(AW), .NSLOT(NSLOT), .STAT_W(STAT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_i), .force_i(force_i),
  .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i), .next_ip_i(next_ip_i),
  .acc_valid_i(acc_valid_i), .acc_kind_i(acc_kind_i), .hit_o(hit_o), .trap_o(trap_o),
  .resume_ip_o(resume_ip_o), .status_o(status_o)
);

// File: tb/tb_dbg_bp_match.sv
module tb_dbg_bp_match;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] slot [4];
  logic [127:0] slot_bus;
  logic [31:0] ctrl, stat_in, fa, nip, aa;
  logic force_r, fv, av;
  logic [3:0] asz;
  logic [1:0] ak;
  logic [3:0] hit;
  logic trap;
  logic [31:0] resume, status;
  logic [31:0] exp_stat;
  int checks = 0, errors = 0;

  assign slot_bus = {slot[3], slot[2], slot[1], slot[0]};

  dbg_bp_match dut (
    .clk_i(clk), .rst_ni(rst_n), .slot_addr_i(slot_bus), .ctrl_i(ctrl),
    .status_i(stat_in), .force_i(force_r), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .next_ip_i(nip), .acc_valid_i(av), .acc_addr_i(aa), .acc_size_i(asz),
    .acc_kind_i(ak), .hit_o(hit), .trap_o(trap), .resume_ip_o(resume),
    .status_o(status)
  );

  function automatic int lenb(input logic [1:0] c);
    return (c == 2'd2) ? 8 : int'(c) + 1;
  endfunction

  // reference model from the requirements
  function automatic void model(output logic [3:0] h, output logic t, output logic [31:0] r);
    logic [3:0] io;
    h = '0; io = '0;
    for (int i = 0; i < 4; i++) begin
      logic en, ov;
      logic [1:0] ty;
      longint lo, hi, alo, ahi;
      en  = ctrl[2*i] | ctrl[2*i+1];
      ty  = ctrl[16+4*i +: 2];
      lo  = longint'(slot[i]);
      hi  = lo + lenb(ctrl[18+4*i +: 2]) - 1;
      alo = longint'(aa);
      ahi = alo + longint'(asz) - 1;
      ov  = av && asz != 0 && alo <= hi && lo <= ahi;
      case (ty)
        2'b00: h[i] = fv && slot[i] == fa;
        2'b01: h[i] = ov && ak == 2'b01;
        2'b11: h[i] = ov && (ak == 2'b00 || ak == 2'b01);
        default: begin io[i] = ov && ak == 2'b10 && en; h[i] = io[i]; end
      endcase
      if (h[i] && en) t = 1'b1;
    end
    t = 1'b0;
    for (int i = 0; i < 4; i++)
      if (h[i] && (ctrl[2*i] | ctrl[2*i+1])) t = 1'b1;
    r = (|io) ? nip : fa;
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs already set at negedge; check combinational outputs, then status after edge
  task automatic run(input string req);
    logic [3:0] eh; logic et; logic [31:0] er;
    #1;
    model(eh, et, er);
    chk32({req, " hit"}, {28'd0, hit}, {28'd0, eh});
    chk32({req, " trap"}, {31'd0, trap}, {31'd0, et});
    chk32({req, " resume R8"}, resume, er);
    if (et || force_r) exp_stat = {stat_in[31:4], eh};
    @(posedge clk); #1;
    chk32({req, " status R7"}, status, exp_stat);
    @(negedge clk);
  endtask

  task automatic idle();
    fv = 0; av = 0; force_r = 0; ak = 2'b11; asz = 0;
  endtask

  task automatic cfg(input int i, input logic [1:0] en, input logic [1:0] ty,
                     input logic [1:0] lc, input logic [31:0] a);
    ctrl[2*i +: 2] = en; ctrl[16+4*i +: 2] = ty; ctrl[18+4*i +: 2] = lc; slot[i] = a;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) slot[i] = 32'h0;
    ctrl = 0; stat_in = 32'hFFFF_0000; fa = 0; nip = 0; aa = 0;
    idle();
    exp_stat = 0;
    #12;
    chk32("R9 reset status", status, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 local-only and global-only enables, R3 exact match
    cfg(0, 2'b01, 2'b00, 2'b00, 32'h1000); cfg(1, 2'b10, 2'b00, 2'b00, 32'h2000);
    fv = 1; fa = 32'h1000; nip = 32'h1004; run("R1 local exec");
    fa = 32'h2000; run("R1 global exec");
    fa = 32'h2001; run("R3 near miss");
    // R3 disabled slot sets hit without trap; force captures it
    cfg(0, 2'b00, 2'b00, 2'b00, 32'h3000); fa = 32'h3000; stat_in = 32'hA5A5_A5A0;
    run("R3 disabled no trap");
    force_r = 1; run("R7 force capture");
    idle(); ctrl = 0;

    // R2 and R5: I/O slot 2 at 0x80, each length code, last byte in and first byte out
    for (int c = 0; c < 4; c++) begin
      cfg(2, 2'b01, 2'b10, c[1:0], 32'h80);
      av = 1; ak = 2'b10; asz = 1; nip = 32'h500 + c;
      aa = 32'h80 + lenb(c[1:0]) - 1; run("R2 R5 io last byte");
      aa = 32'h80 + lenb(c[1:0]);     run("R2 R5 io past end");
    end
    aa = 32'h7E; asz = 2; cfg(2, 2'b01, 2'b10, 2'b00, 32'h80); run("R5 io low overlap miss");
    asz = 3; run("R5 io low overlap hit");
    cfg(2, 2'b00, 2'b10, 2'b00, 32'h80); run("R5 disabled io ignored");
    idle(); ctrl = 0;

    // R4 write watch and read/write watch
    cfg(3, 2'b11, 2'b01, 2'b11, 32'h2000);
    av = 1; ak = 2'b00; aa = 32'h2000; asz = 4; run("R4 write watch ignores read");
    ak = 2'b01; aa = 32'h1FFE; asz = 2; run("R4 write below range");
    asz = 3; run("R4 write overlapping");
    asz = 0; run("R4 zero size");
    cfg(3, 2'b11, 2'b11, 2'b11, 32'h2000); ak = 2'b00; aa = 32'h2003; asz = 1;
    run("R4 rw watch read");
    ak = 2'b11; run("R4 kind none");
    idle();

    // constrained random mix
    void'($urandom(32'd12345));
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 4; i++) slot[i] = 32'h100 + ($urandom % 16);
      ctrl = $urandom; stat_in = $urandom;
      fv = $urandom % 2; fa = 32'h100 + ($urandom % 16); nip = $urandom;
      av = $urandom % 2; aa = 32'h100 + ($urandom % 16);
      asz = 4'($urandom % 9); ak = 2'($urandom % 4); force_r = ($urandom % 4) == 0;
      run("R1 R3 R4 R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule